// File: doc/BRIEF.md
# Serial Audio Link Output Slot Assembler (Control, Subwoofer and Reserved Slots)

This block prepares, once per frame, the contents of a few slots of an outgoing serial audio link frame. The slots are the codec command slots (address and data), the subwoofer playback slot, the two reserved slots, and the slot that carries a 16-bit modem line-interface and general-purpose pin control word. A host writes the control word through a simple write port, at one address for the primary codec and another for the secondary codec. The bit serializer that follows samples the registered slot outputs and valid flags, and holds them for a whole frame.

The control slot starts out invalid. The first accepted write arms it. From the next frame boundary on, it is flagged valid in every frame and carries the most recent value written. The frame that directly follows each accepted write also carries the matching register write command in the address and data slots. A host bus reset, a cold link reset or a warm link reset (a wake from deep sleep counts as one) puts the control slot back to invalid until the next write. Writes are collected during a frame and take effect only at the next boundary, so no slot changes partway through a frame.

The control logic is a four-state machine:
- `GS_INVALID`: no value held. An accepted write goes to `GS_FIRST_PEND`.
- `GS_FIRST_PEND`: the first value waits for a boundary. A boundary goes to `GS_VALID`, or to `GS_UPDATE_PEND` if another write arrives in the same cycle.
- `GS_VALID`: the slot is live. An accepted write goes to `GS_UPDATE_PEND`.
- `GS_UPDATE_PEND`: a new value waits for a boundary. A boundary goes to `GS_VALID`, or stays in `GS_UPDATE_PEND` if another write arrives in the same cycle.

A cold or warm reset sends any state to `GS_INVALID`, and so does `rst_n` low.

Top module: `aclink_slot_builder`

## Requirements
- R1: After `rst_n` is released, `slot12_valid`, `slot1_valid` and `slot2_valid` are 0, and `slot12_data` is 0.
- R2: A write with `wr_addr` 8'h54 or 8'hD4 makes, at the next boundary (`frame_start` high at a clock edge), `slot12_valid` 1 and `slot12_data` = {wr_data, 4'b0000}.
- R3: In that same frame, `slot1_valid` and `slot2_valid` are 1. `slot1_data` = {1'b0 (write), wr_addr[6:0], 12'b0} and `slot2_data` = {wr_data, 4'b0000}. `cmd_secondary` is 0 for 8'h54 and 1 for 8'hD4.
- R4: At a boundary with no write since the last one, `slot1_valid`, `slot2_valid` and `cmd_secondary` are 0. `slot12_valid` keeps its value and `slot12_data` keeps the last value written.
- R5: When several accepted writes fall between two boundaries, only the last one is sent.
- R6: A write to any other address changes no output at the next boundary.
- R7: The outputs change only at a boundary or a reset. A write in the same cycle as a boundary takes effect at the following boundary.
- R8: A `cold_rst` or `warm_rst` pulse makes `slot12_valid` and `slot1_valid` 0 in the next cycle. It also discards a pending write. The slot stays invalid across later boundaries until a new write.
- R9: At a boundary with `six_ch_en` 1, `slot9_valid` is 1 and `slot9_data` = `sub_data`. With `six_ch_en` 0, both are 0.
- R10: `slot10_data` and `slot11_data` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Host bus reset, active low, asynchronous |
| cold_rst | input | 1 | Cold link reset pulse, synchronous |
| warm_rst | input | 1 | Warm link reset or wake pulse, synchronous |
| frame_start | input | 1 | Frame boundary strobe |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write address |
| wr_data | input | 16 | Host write data (control word) |
| six_ch_en | input | 1 | Six-channel playback enable |
| sub_data | input | 20 | Subwoofer sample for the next frame |
| slot1_valid | output | 1 | Command address slot tag |
| slot1_data | output | 20 | Command address slot |
| slot2_valid | output | 1 | Command data slot tag |
| slot2_data | output | 20 | Command data slot |
| cmd_secondary | output | 1 | Command targets the secondary codec |
| slot9_valid | output | 1 | Subwoofer slot tag |
| slot9_data | output | 20 | Subwoofer slot |
| slot10_data | output | 20 | Reserved slot, zero |
| slot11_data | output | 20 | Reserved slot, zero |
| slot12_valid | output | 1 | Control slot tag |
| slot12_data | output | 20 | Control slot, word left-justified |

## Verification
The hardest cases to reach are two events landing in the same clock cycle. In the first, a write arrives on the very edge of a boundary: it must miss that boundary and appear one frame later, while the value that was already pending goes out. In the second, a reset removes a write that is still pending, and the slot must stay invalid across later boundaries. The bench drives `frame_start` together with `wr_en` on one edge, and pulses `cold_rst` or `warm_rst` between a write and its boundary. It then follows each case for several more frames with no writes.

// File: rtl/aclink_slot_pkg.sv
package aclink_slot_pkg;
    localparam int SLOT_W = 20;
    localparam int GPIO_W = 16;
    localparam int IDX_W  = 7;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        GS_INVALID     = 2'd0,
        GS_FIRST_PEND  = 2'd1,
        GS_VALID       = 2'd2,
        GS_UPDATE_PEND = 2'd3
    } gstate_t;
endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] PRI_ADDR = 8'h54,
    parameter logic [ADDR_W-1:0] SEC_ADDR = 8'hD4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              hit,
    output logic              hit_sec
);
    always_comb begin
        hit_sec = wr_en && (wr_addr == SEC_ADDR);
        hit     = hit_sec || (wr_en && (wr_addr == PRI_ADDR));
    end
endmodule

// File: rtl/gpio_slot_fsm.sv
module gpio_slot_fsm
    import aclink_slot_pkg::*;
#(
    parameter int DW = GPIO_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          frame_start,
    input  logic          hit,
    input  logic          hit_sec,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic          apply_cmd,
    output logic          slot_live,
    output logic          pend_sec,
    output logic [IW-1:0] pend_idx,
    output logic [DW-1:0] pend_data
);
    gstate_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            GS_INVALID:     if (hit) state_nx = GS_FIRST_PEND;
            GS_FIRST_PEND:  if (frame_start) state_nx = hit ? GS_UPDATE_PEND : GS_VALID;
            GS_VALID:       if (hit) state_nx = GS_UPDATE_PEND;
            GS_UPDATE_PEND: if (frame_start) state_nx = hit ? GS_UPDATE_PEND : GS_VALID;
            default:        state_nx = GS_INVALID;
        endcase
        if (soft_clr) state_nx = GS_INVALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GS_INVALID;
        else        state <= state_nx;
    end

    always_comb begin
        apply_cmd = 1'b0;
        slot_live = 1'b0;
        unique case (state)
            GS_INVALID:     ;
            GS_FIRST_PEND:  begin apply_cmd = frame_start; slot_live = 1'b1; end
            GS_VALID:       slot_live = 1'b1;
            GS_UPDATE_PEND: begin apply_cmd = frame_start; slot_live = 1'b1; end
            default:        ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_sec  <= 1'b0;
            pend_idx  <= '0;
            pend_data <= '0;
        end else if (hit && !soft_clr) begin
            pend_sec  <= hit_sec;
            pend_idx  <= wr_idx;
            pend_data <= wr_data;
        end
    end
endmodule

// File: rtl/frame_slot_regs.sv
module frame_slot_regs
    import aclink_slot_pkg::*;
#(
    parameter int SW = SLOT_W,
    parameter int DW = GPIO_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          frame_start,
    input  logic          apply_cmd,
    input  logic          slot_live,
    input  logic          cmd_sec,
    input  logic [IW-1:0] cmd_idx,
    input  logic [DW-1:0] cmd_data,
    input  logic          six_ch_en,
    input  logic [SW-1:0] sub_data,
    output logic          s1_valid,
    output logic [SW-1:0] s1_data,
    output logic          s2_valid,
    output logic [SW-1:0] s2_data,
    output logic          sec_q,
    output logic          s9_valid,
    output logic [SW-1:0] s9_data,
    output logic          s12_valid,
    output logic [SW-1:0] s12_data
);
    localparam int PADW = SW - DW;
    localparam int LOW1 = SW - 1 - IW;

    logic [SW-1:0] word_just;
    logic [SW-1:0] addr_word;

    assign word_just = {cmd_data, {PADW{1'b0}}};
    assign addr_word = {1'b0, cmd_idx, {LOW1{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_data   <= '0;
            s2_valid  <= 1'b0;
            s2_data   <= '0;
            sec_q     <= 1'b0;
            s9_valid  <= 1'b0;
            s9_data   <= '0;
            s12_valid <= 1'b0;
            s12_data  <= '0;
        end else if (soft_clr) begin
            s1_valid  <= 1'b0;
            s1_data   <= '0;
            s2_valid  <= 1'b0;
            s2_data   <= '0;
            sec_q     <= 1'b0;
            s12_valid <= 1'b0;
            s12_data  <= '0;
        end else if (frame_start) begin
            s1_valid  <= apply_cmd;
            s2_valid  <= apply_cmd;
            sec_q     <= apply_cmd && cmd_sec;
            s1_data   <= apply_cmd ? addr_word : '0;
            s2_data   <= apply_cmd ? word_just : '0;
            s12_valid <= slot_live;
            if (apply_cmd) s12_data <= word_just;
            s9_valid  <= six_ch_en;
            s9_data   <= six_ch_en ? sub_data : '0;
        end
    end
endmodule

// File: rtl/aclink_slot_builder.sv
module aclink_slot_builder
    import aclink_slot_pkg::*;
#(
    parameter int SW = SLOT_W,
    parameter int DW = GPIO_W,
    parameter int AW = ADDR_W,
    parameter logic [AW-1:0] PRI_ADDR = 8'h54,
    parameter logic [AW-1:0] SEC_ADDR = 8'hD4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cold_rst,
    input  logic          warm_rst,
    input  logic          frame_start,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          six_ch_en,
    input  logic [SW-1:0] sub_data,
    output logic          slot1_valid,
    output logic [SW-1:0] slot1_data,
    output logic          slot2_valid,
    output logic [SW-1:0] slot2_data,
    output logic          cmd_secondary,
    output logic          slot9_valid,
    output logic [SW-1:0] slot9_data,
    output logic [SW-1:0] slot10_data,
    output logic [SW-1:0] slot11_data,
    output logic          slot12_valid,
    output logic [SW-1:0] slot12_data
);
    localparam int IW = IDX_W;

    logic          soft_clr, hit, hit_sec, apply_cmd, slot_live, pend_sec;
    logic [IW-1:0] pend_idx;
    logic [DW-1:0] pend_data;

    assign soft_clr = cold_rst | warm_rst;

    gpio_wr_decode #(.ADDR_W(AW), .PRI_ADDR(PRI_ADDR), .SEC_ADDR(SEC_ADDR)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .hit(hit), .hit_sec(hit_sec)
    );

    gpio_slot_fsm #(.DW(DW), .IW(IW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .frame_start(frame_start),
        .hit(hit), .hit_sec(hit_sec), .wr_idx(wr_addr[IW-1:0]), .wr_data(wr_data),
        .apply_cmd(apply_cmd), .slot_live(slot_live), .pend_sec(pend_sec),
        .pend_idx(pend_idx), .pend_data(pend_data)
    );

    frame_slot_regs #(.SW(SW), .DW(DW), .IW(IW)) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .frame_start(frame_start),
        .apply_cmd(apply_cmd), .slot_live(slot_live), .cmd_sec(pend_sec),
        .cmd_idx(pend_idx), .cmd_data(pend_data), .six_ch_en(six_ch_en),
        .sub_data(sub_data), .s1_valid(slot1_valid), .s1_data(slot1_data),
        .s2_valid(slot2_valid), .s2_data(slot2_data), .sec_q(cmd_secondary),
        .s9_valid(slot9_valid), .s9_data(slot9_data),
        .s12_valid(slot12_valid), .s12_data(slot12_data)
    );

    // Reserved slots are stuffed with zeros (R10)
    assign slot10_data = '0;
    assign slot11_data = '0;
endmodule

// File: rtl/aclink_slot_checker.sv
module aclink_slot_checker #(
    parameter int SW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cold_rst,
    input logic          warm_rst,
    input logic          frame_start,
    input logic          slot1_valid,
    input logic          slot2_valid,
    input logic          slot9_valid,
    input logic [SW-1:0] slot9_data,
    input logic          slot12_valid,
    input logic [SW-1:0] slot12_data,
    input logic [SW-1:0] slot1_data
);
    a_r7_stable_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !cold_rst && !warm_rst) |=>
            ($stable(slot12_valid) && $stable(slot12_data) && $stable(slot1_valid) && $stable(slot1_data)));

    a_r8_reset_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        (cold_rst || warm_rst) |=> (!slot12_valid && !slot1_valid && !slot2_valid));

    a_r3_cmd_needs_live_slot: assert property (@(posedge clk) disable iff (!rst_n)
        slot1_valid |-> (slot12_valid && slot2_valid));

    a_r2_rise_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot12_valid) |-> $past(frame_start));

    a_r9_sub_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !slot9_valid |-> (slot9_data == '0));
endmodule

bind aclink_slot_builder aclink_slot_checker #(.SW(SW)) i_chk (
    .clk(clk), .rst_n(rst_n), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .frame_start(frame_start), .slot1_valid(slot1_valid), .slot2_valid(slot2_valid),
    .slot9_valid(slot9_valid), .slot9_data(slot9_data), .slot12_valid(slot12_valid),
    .slot12_data(slot12_data), .slot1_data(slot1_data)
);

// File: tb/test_aclink_slot_builder.sv
module test_aclink_slot_builder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cold_rst = 1'b0, warm_rst = 1'b0, frame_start = 1'b0, wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        six_ch_en = 1'b0;
    logic [19:0] sub_data = '0;
    logic        slot1_valid, slot2_valid, cmd_secondary, slot9_valid, slot12_valid;
    logic [19:0] slot1_data, slot2_data, slot9_data, slot10_data, slot11_data, slot12_data;

    always #10 clk = ~clk;

    aclink_slot_builder i_aclink_slot_builder (.*);

    typedef struct {
        logic v1; logic [19:0] d1; logic [19:0] d2; logic sec;
        logic v12; logic [19:0] d12; logic v9; logic [19:0] d9;
        string req;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_fail = 0;
    logic m_live = 0, m_pend = 0;
    logic [15:0] m_pd = 0, m_d12w = 0;
    logic [7:0] m_pa = 0;
    logic fs_seen = 0;
    logic done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic exp_t predict(input string req);
        exp_t e;
        e.req = req;
        if (m_pend) begin
            m_live = 1; m_d12w = m_pd; m_pend = 0;
            e.v1 = 1; e.d1 = {1'b0, m_pa[6:0], 12'h000}; e.d2 = {m_pd, 4'h0};
            e.sec = (m_pa == 8'hD4);
        end else begin
            e.v1 = 0; e.d1 = 0; e.d2 = 0; e.sec = 0;
        end
        e.v12 = m_live;
        e.d12 = m_live ? {m_d12w, 4'h0} : 20'h0;
        e.v9 = six_ch_en;
        e.d9 = six_ch_en ? sub_data : 20'h0;
        return e;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [15:0] d);
        if (a == 8'h54 || a == 8'hD4) begin
            m_pend = 1; m_pa = a; m_pd = d;
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        model_write(a, d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic boundary(input string req);
        @(negedge clk);
        q.push_back(predict(req));
        frame_start = 1;
        @(negedge clk);
        frame_start = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic boundary_with_write(input logic [7:0] a, input logic [15:0] d, input string req);
        @(negedge clk);
        q.push_back(predict(req));
        model_write(a, d);
        frame_start = 1; wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        frame_start = 0; wr_en = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic link_reset(input bit cold);
        @(negedge clk);
        if (cold) cold_rst = 1; else warm_rst = 1;
        m_live = 0; m_pend = 0; m_d12w = 0;
        @(negedge clk);
        cold_rst = 0; warm_rst = 0;
        chk(slot12_valid == 0 && slot1_valid == 0 && slot12_data == 0, "R8",
            "valid/data after link reset", {slot12_valid, slot1_valid, slot12_data}, 0);
    endtask

    always @(posedge clk) fs_seen <= frame_start;

    // monitor: pops one expected item per boundary
    always @(negedge clk) begin
        if (fs_seen && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(slot1_valid == e.v1 && slot2_valid == e.v1, e.req, "slot1/2 valid",
                {slot1_valid, slot2_valid}, {e.v1, e.v1});
            chk(slot1_data == e.d1 && slot2_data == e.d2 && cmd_secondary == e.sec, e.req,
                "slot1/2 data, secondary", {cmd_secondary, slot1_data[18:12], slot2_data[19:4]},
                {e.sec, e.d1[18:12], e.d2[19:4]});
            chk(slot12_valid == e.v12 && slot12_data == e.d12, e.req, "slot12",
                {slot12_valid, slot12_data}, {e.v12, e.d12});
            chk(slot9_valid == e.v9 && slot9_data == e.d9, "R9", "slot9",
                {slot9_valid, slot9_data}, {e.v9, e.d9});
            chk(slot10_data == 0 && slot11_data == 0, "R10", "reserved slots",
                {slot10_data[15:0], slot11_data[15:0]}, 0);
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(slot12_valid == 0 && slot1_valid == 0 && slot2_valid == 0 && slot12_data == 0,
            "R1", "reset state", {slot12_valid, slot1_valid, slot12_data}, 0);
        boundary("R1");                       // still invalid without write
        bus_write(8'h54, 16'hA5C3);
        chk(slot12_valid == 0, "R7", "no change before boundary", slot12_valid, 0);
        boundary("R2");                       // first write, primary, R3
        boundary("R4");                       // sticky, command gone
        six_ch_en = 1; sub_data = 20'h7BEEF;
        bus_write(8'hD4, 16'h1234);
        boundary("R3");                       // secondary command
        bus_write(8'h54, 16'h1111);
        bus_write(8'hD4, 16'h2222);
        bus_write(8'h54, 16'h3333);
        boundary("R5");                       // last wins
        six_ch_en = 0;
        bus_write(8'h55, 16'hFFFF);
        bus_write(8'h00, 16'hDEAD);
        boundary("R6");                       // ignored addresses
        boundary_with_write(8'hD4, 16'h4242, "R7");
        boundary("R7");                       // same-cycle write lands now
        boundary("R4");
        link_reset(1);
        boundary("R8");
        bus_write(8'h54, 16'h0F0F);
        link_reset(0);                        // discards pending write
        boundary("R8");
        boundary("R8");
        bus_write(8'h54, 16'hBEEF);
        boundary("R2");
        six_ch_en = 1; sub_data = 20'h00001;
        boundary("R9");
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R7", "all boundaries observed", q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule